// File: doc/BRIEF.md
# Sampled-Stream Clock and Data Recovery

This block turns a stream of digitized line samples back into serial bits when the far end sends no clock. Each sample arrives with a strobe and is sliced against a run-time threshold into a binary level. The block watches for changes in that level: every change is taken as the start of a new bit cell. Between changes it extrapolates cell boundaries by counting a fixed number of samples per bit.

From each cell the block picks the sample at the centre and presents its level as a recovered bit, together with a one-cycle valid pulse. The incoming data is assumed to carry level changes often enough that the small rate difference between the transmitter and receiver never moves the centre pick out of its cell.

Top module: `sample_cdr`

## Requirements
- R1: A strobed sample slices to level 1 when its unsigned value is greater than or equal to the threshold input, and to level 0 otherwise. A sample exactly at the threshold gives 1.
- R2: After reset, bit_valid is 0 and no bit is emitted until the first change between two strobed levels has been seen.
- R3: A strobed sample whose level differs from the previous strobed level counts as index 0 of a new cell. Cell timing restarts from it.
- R4: When no level change occurs, a new cell starts every SPB strobed samples after the last cell start. A level run of k·SPB samples therefore yields k bits.
- R5: The bit of a cell is decided from its sample at index SPB/2 (rounded down). Cell indices count from 0. The bit is presented on bit_out with bit_valid high for exactly one clock, in the clock after the one whose edge took that sample.
- R6: A cell that ends on a level change before its centre index is reached emits no bit. A cell that reaches its centre index before the change emits exactly one bit.
- R7: Clocks with smp_valid low have no effect on the level history or the cell timing, whatever smp_data holds.
- R8: With SPB = 8, the bit sequence following the first level change is recovered without error under two conditions: sample noise stays inside the margin around the threshold, and some cells are stretched or shrunk by one sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Strobe: smp_data holds a sample this cycle |
| smp_data | input | SMP_W | Unsigned line sample |
| thresh | input | SMP_W | Slicing threshold |
| bit_out | output | 1 | Last recovered bit |
| bit_valid | output | 1 | One-cycle pulse marking a new recovered bit |

## Verification
A level change can arrive on exactly the sample that the extrapolated timing would treat as a cell's centre. In that cycle the restart of cell timing and the bit decision collide. The bench provokes this by cutting a cell to SPB/2 samples, so the next change lands on the centre index. The expected result is that the change wins: no bit for the short cell, timing restarting there. A second case cuts a cell to SPB/2+1 samples and expects the centre bit to be emitted before the restart.

// File: rtl/cdr_pkg.sv
`timescale 1ns/1ps
package cdr_pkg;
  // Result of slicing one strobed sample
  typedef struct packed {
    logic vld;   // sample present this cycle
    logic lvl;   // sliced binary level
    logic chg;   // level differs from previous strobed level
  } slice_t;
endpackage

// File: rtl/cdr_rst_sync.sv
`timescale 1ns/1ps
module cdr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sh_q[STAGES-1];
endmodule

// File: rtl/cdr_slicer.sv
`timescale 1ns/1ps
module cdr_slicer
  import cdr_pkg::*;
#(
  parameter int SMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [SMP_W-1:0] thresh,
  output slice_t           sl
);
  logic hist_q, hist_d;   // a previous level exists
  logic prv_q, prv_d;     // previous strobed level
  logic lvl_now;

  always_comb begin
    lvl_now = (smp_data >= thresh);
    hist_d  = hist_q;
    prv_d   = prv_q;
    if (smp_valid) begin
      hist_d = 1'b1;
      prv_d  = lvl_now;
    end
    sl.vld = smp_valid;
    sl.lvl = lvl_now;
    sl.chg = smp_valid && hist_q && (lvl_now != prv_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      prv_q  <= 1'b0;
    end else if (smp_valid) begin
      hist_q <= hist_d;
      prv_q  <= prv_d;
    end
  end

  // R7: idle clocks leave the level history untouched
  a_r7_hist_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(prv_q) && $stable(hist_q));
endmodule

// File: rtl/cdr_cell_timer.sv
`timescale 1ns/1ps
module cdr_cell_timer #(
  parameter int SPB = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  input  logic chg,
  output logic emit
);
  localparam int CNT_W = (SPB > 2) ? $clog2(SPB) : 1;
  localparam int MID   = SPB / 2;
  localparam logic [CNT_W-1:0] MID_C  = CNT_W'(MID);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(SPB - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;   // index of the next strobed sample
  logic [CNT_W-1:0] idx;            // index of the current sample
  logic             algn_q, algn_d; // cell timing established

  always_comb begin
    idx    = chg ? '0 : cnt_q;
    emit   = smp_valid && (algn_q || chg) && (idx == MID_C);
    cnt_d  = cnt_q;
    algn_d = algn_q;
    if (smp_valid) begin
      if (chg) begin
        cnt_d  = CNT_W'(1);
        algn_d = 1'b1;
      end else if (algn_q) begin
        cnt_d = (cnt_q == LAST_C) ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      algn_q <= 1'b0;
    end else if (smp_valid) begin
      cnt_q  <= cnt_d;
      algn_q <= algn_d;
    end
  end

  // R4: the counter stays inside one cell
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_C);
  // R6: a level change never yields a bit in its own cycle
  a_r6_no_emit_on_chg: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> !emit);
  // R2: nothing before alignment
  a_r2_quiet_unaligned: assert property (@(posedge clk) disable iff (!rst_n)
    !algn_q |-> !emit);
  // R7: idle clocks do not advance timing
  a_r7_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(cnt_q) && $stable(algn_q));
endmodule

// File: rtl/sample_cdr.sv
`timescale 1ns/1ps
module sample_cdr
  import cdr_pkg::*;
#(
  parameter int SMP_W = 8,
  parameter int SPB   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [SMP_W-1:0] thresh,
  output logic             bit_out,
  output logic             bit_valid
);
  logic   rst_n_s;
  slice_t sl;
  logic   emit;
  logic   bit_q, bit_d;
  logic   bv_q, bv_d;

  cdr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  cdr_slicer #(.SMP_W(SMP_W)) u_slc (
    .clk(clk), .rst_n(rst_n_s), .smp_valid(smp_valid),
    .smp_data(smp_data), .thresh(thresh), .sl(sl)
  );

  cdr_cell_timer #(.SPB(SPB)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .smp_valid(sl.vld),
    .chg(sl.chg), .emit(emit)
  );

  always_comb begin
    bv_d  = emit;
    bit_d = emit ? sl.lvl : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      bv_q  <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      bv_q  <= bv_d;
      bit_q <= bit_d;
    end
  end

  assign bit_out   = bit_q;
  assign bit_valid = bv_q;

  // R5: each recovered bit is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n_s)
    bit_valid |=> !bit_valid);
  // R5: bit_out only moves together with a new bit
  a_r5_bit_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bit_valid |-> bit_out == $past(bit_out));
endmodule

// File: tb/sample_cdr_tb.sv
`timescale 1ns/1ps
module sample_cdr_tb;
  localparam int SMP_W = 8;
  localparam int SPB   = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             smp_valid;
  logic [SMP_W-1:0] smp_data;
  logic [SMP_W-1:0] thresh;
  logic             bit_out;
  logic             bit_valid;

  int total = 0;
  int bad   = 0;
  logic rec [0:255];
  int   nrec = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  sample_cdr #(.SMP_W(SMP_W), .SPB(SPB)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .thresh(thresh), .bit_out(bit_out), .bit_valid(bit_valid)
  );

  always @(negedge clk) begin
    if (rst_n && bit_valid) begin
      if (nrec < 256) rec[nrec] = bit_out;
      nrec = nrec + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; thresh = 8'd128;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    nrec = 0;
  endtask

  // one strobed sample, optional idle clocks with junk data after it
  task automatic put(input logic [SMP_W-1:0] v, input int gap = 0);
    smp_valid = 1'b1; smp_data = v;
    @(negedge clk);
    smp_valid = 1'b0;
    for (int g = 0; g < gap; g++) begin
      smp_data = ~v;
      @(negedge clk);
    end
  endtask

  task automatic put_run(input logic [SMP_W-1:0] v, input int n, input int gap = 0);
    for (int i = 0; i < n; i++) put(v, gap);
  endtask

  task automatic chk_seq(input string req, input logic [63:0] exp, input int n);
    chk({req, " count"}, nrec, n);
    for (int i = 0; i < n && i < nrec; i++)
      chk({req, " bit"}, int'(rec[i]), int'(exp[n-1-i]));
  endtask

  task automatic t_reset();
    do_reset();
    chk("R2 reset bit_valid", int'(bit_valid), 0);
    chk("R2 reset bit_out", int'(bit_out), 0);
    put_run(8'd20, 30);
    chk("R2 no bits before first change", nrec, 0);
  endtask

  task automatic t_latency();
    do_reset();
    put_run(8'd20, 8);
    for (int i = 0; i < 16; i++) begin
      put(8'd220);
      chk("R5 R4 pulse at centre index", int'(bit_valid),
          ((i % SPB) == SPB/2) ? 1 : 0);
      if ((i % SPB) == SPB/2) chk("R5 bit level", int'(bit_out), 1);
    end
    chk("R4 extrapolated bit count", nrec, 2);
  endtask

  task automatic t_thresh();
    do_reset();
    thresh = 8'd100;
    put_run(8'd99, 8); put_run(8'd100, 8); put_run(8'd99, 8);
    chk_seq("R1 at-threshold slices to 1", 64'b10, 2);
    do_reset();
    thresh = 8'd255;
    put_run(8'd254, 8); put_run(8'd255, 8); put_run(8'd0, 8);
    chk_seq("R1 top-of-range threshold", 64'b10, 2);
  endtask

  task automatic t_short();
    do_reset();
    put_run(8'd20, 8); put_run(8'd220, SPB/2); put_run(8'd20, 8); put_run(8'd220, 8);
    chk_seq("R6 R3 change on centre index", 64'b01, 2);
    do_reset();
    put_run(8'd20, 8); put_run(8'd220, SPB/2 + 1); put_run(8'd20, 8);
    chk_seq("R6 centre reached before change", 64'b10, 2);
  endtask

  task automatic t_gaps();
    do_reset();
    put_run(8'd20, 8, 2); put_run(8'd220, 8, 3); put_run(8'd20, 16, 1);
    chk_seq("R7 idle clocks ignored", 64'b100, 3);
  endtask

  task automatic t_noise();
    logic [23:0] pat;
    int len, nz, v;
    pat = 24'b011010001110010110111001;
    do_reset();
    thresh = 8'd128;
    for (int c = 0; c < 24; c++) begin
      len = SPB + (((c % 5) == 2) ? 1 : (((c % 5) == 4) ? -1 : 0));
      for (int s = 0; s < len; s++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        nz = int'(lfsr % 16'd61) - 30;
        v  = (pat[23-c] ? 210 : 40) + nz;
        put(SMP_W'(v));
      end
    end
    chk_seq("R8 R4 noisy mismatched stream", {40'd0, pat}, 23);
  endtask

  initial begin
    #(4 * 150000);
    bad = bad + 1; total = total + 1;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_thresh();
    t_short();
    t_gaps();
    t_noise();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule